// File: doc/BRIEF.md
# Character Display Command Processor

This block is the host-facing command engine of a text display holding 32 characters in two rows of sixteen. A host processor writes command and character bytes to address 0 and polls a ready flag at the same address before it writes again. Each accepted byte either stores a character at the cursor or runs a command that moves the cursor and reads back a character, sets how many positions are in use, or sets the display enable and blink bits. Every accepted byte holds the flag low for a fixed, command-specific number of microseconds. Those microseconds are counted from a clock-per-microsecond parameter.

A downstream renderer chooses a position and gets back the stored character, whether that position is lit at this moment, and whether the blinking cursor is shown there. Glyph lookup and pixel drive happen outside this block.

Top module: `chardisp_cmd`

## Requirements
- R1: After reset the status byte reads 0x08: ready, no error, display off, no blinking. The output register reads 0x00, every character cell holds 0x20, the cursor is 0 and the length is 32. While the display is off, no position is lit.
- R2: A write to address 0 while ready is accepted. Status bit 3 then reads 0 for exactly N × CLK_PER_US cycles after the accepting edge, and reads 1 again after that. N is CHR_US for a character byte or a no-op byte, LCR_US for cursor load-and-read, LDL_US for the length command and LDS_US for the status command.
- R3: An accepted byte with bits 7:6 = 00 stores {00, bits 5:0} in the cell at the cursor. The renderer reads it back at that position.
- R4: After each character store the cursor steps by one. It returns to 0 when the next value would reach the programmed length.
- R5: The byte 100ppppp loads p into the cursor and copies cell p into the output register.
- R6: The byte 101nnnnn sets the length to n+1. If the cursor is not below the new length, the cursor is reset to 0. Positions at or beyond the length are never lit.
- R7: The byte 01xxxedc sets the display status bits: e (bit 2) enables the display, d (bit 1) blinks the whole display and c (bit 0) enables the blinking cursor. These bits read back on status bits 2:0.
- R8: A write to address 0 while busy changes neither the cells nor the cursor. It sets status bit 4, which stays set until reset.
- R9: A blink phase starts at 0 on reset and toggles every BLINK_US × CLK_PER_US cycles. With d set, all positions go dark during phase 1. With e and c set, the cursor output is high at the cursor position only during phase 1.
- R10: A read at address 0 returns the status byte {000, error, ready, e, d, c}. A read at address 1 returns the output register. Writes to address 1 have no effect.
- R11: A byte with bits 7:6 = 11 is a no-op. It busies the block for CHR_US and changes neither the cells, the cursor nor the status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Host address: 0 command/status, 1 output register |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, combinational on bus_addr |
| view_pos | input | 5 | Renderer position select |
| view_char | output | 8 | Character stored at view_pos |
| view_on | output | 1 | Position view_pos is lit now |
| view_cursor | output | 1 | Cursor shown at view_pos now |

## Verification
Effects on the cells, the cursor, the output register and the status bits take place at the accepting edge. The bench therefore drives on a falling edge and reads the ports on the next falling edge. The busy window is measured by counting falling edges while status bit 3 is 0, and the count must equal N × CLK_PER_US exactly. Blink timing is measured the same way, from one transition of view_on or view_cursor to the next, against BLINK_US × CLK_PER_US. Renderer outputs are combinational, so the bench sweeps every position one cycle after it sets it.

// File: rtl/chardisp_cmd.sv
module chardisp_cmd #(
  parameter int ROWS       = 2,
  parameter int COLS       = 16,
  parameter int CLK_PER_US = 50,
  parameter int CHR_US     = 40,
  parameter int LCR_US     = 150,
  parameter int LDL_US     = 100,
  parameter int LDS_US     = 100,
  parameter int BLINK_US   = 500000,
  localparam int DEPTH     = ROWS * COLS,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [AW-1:0] view_pos,
  output logic [7:0]    view_char,
  output logic          view_on,
  output logic          view_cursor
);
  localparam int PW = $clog2(CLK_PER_US + 1);
  localparam int BW = $clog2(BLINK_US + 1);
  localparam int TW = 16;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] cursor;
  logic [AW:0]   len;
  logic [7:0]    outreg;
  logic          dsp_e, dsp_d, dsp_c;
  logic          busy, err;
  logic [PW-1:0] pre;
  logic [TW-1:0] us_left;
  logic [PW-1:0] bpre;
  logic [BW-1:0] bcnt;
  logic          phase;
  logic [TW-1:0] exec_us;

  wire           accept = bus_wr && !bus_addr && !busy;
  wire           clash  = bus_wr && !bus_addr && busy;
  wire [1:0]     kind   = bus_wdata[7:6];
  wire [AW-1:0]  opnd   = bus_wdata[AW-1:0];
  wire [AW:0]    nxt    = {1'b0, cursor} + 1'b1;
  wire [AW:0]    newlen = {1'b0, opnd} + 1'b1;

  always_comb begin
    case (kind)
      2'b01:   exec_us = TW'(LDS_US);
      2'b10:   exec_us = bus_wdata[5] ? TW'(LDL_US) : TW'(LCR_US);
      default: exec_us = TW'(CHR_US);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      err     <= 1'b0;
      pre     <= '0;
      us_left <= '0;
    end else begin
      if (clash) err <= 1'b1;
      if (accept) begin
        busy    <= 1'b1;
        pre     <= '0;
        us_left <= exec_us;
      end else if (busy) begin
        if (pre == PW'(CLK_PER_US - 1)) begin
          pre     <= '0;
          us_left <= us_left - 1'b1;
          if (us_left == TW'(1)) busy <= 1'b0;
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h20;
      cursor <= '0;
      len    <= (AW+1)'(DEPTH);
      outreg <= 8'h00;
      dsp_e  <= 1'b0;
      dsp_d  <= 1'b0;
      dsp_c  <= 1'b0;
    end else if (accept) begin
      case (kind)
        2'b00: begin
          mem[cursor] <= {2'b00, bus_wdata[5:0]};
          cursor      <= (nxt >= len) ? '0 : nxt[AW-1:0];
        end
        2'b01: begin
          dsp_e <= bus_wdata[2];
          dsp_d <= bus_wdata[1];
          dsp_c <= bus_wdata[0];
        end
        2'b10: begin
          if (bus_wdata[5]) begin
            len <= newlen;
            if ({1'b0, cursor} >= newlen) cursor <= '0;
          end else begin
            cursor <= opnd;
            outreg <= mem[opnd];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpre  <= '0;
      bcnt  <= '0;
      phase <= 1'b0;
    end else if (bpre == PW'(CLK_PER_US - 1)) begin
      bpre <= '0;
      if (bcnt == BW'(BLINK_US - 1)) begin
        bcnt  <= '0;
        phase <= ~phase;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end else begin
      bpre <= bpre + 1'b1;
    end
  end

  assign bus_rdata   = bus_addr ? outreg : {3'b000, err, ~busy, dsp_e, dsp_d, dsp_c};
  assign view_char   = mem[view_pos];
  assign view_on     = dsp_e && ({1'b0, view_pos} < len) && !(dsp_d && phase);
  assign view_cursor = dsp_e && dsp_c && (view_pos == cursor) && phase;

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r8_clash_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> err);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r8_clash_keeps_cursor: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> $stable(cursor));
  a_r4_cursor_below_len: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == 2'b00) |=> ({1'b0, cursor} < len));
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len >= 1) && (len <= (AW+1)'(DEPTH)));
endmodule

// File: tb/chardisp_cmd_test.sv
module chardisp_cmd_test;
  localparam int PERIOD = 10;
  localparam int CPU = 2, CHR = 3, LCR = 5, LDL = 4, LDS = 2, BLK = 50;

  logic       clk = 0, rst_n = 0, bus_addr = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [4:0] view_pos = 0;
  logic [7:0] view_char;
  logic       view_on, view_cursor;
  int tests = 0, fails = 0;
  logic [7:0] model [32];
  int cur = 0, len = 32;

  chardisp_cmd #(.CLK_PER_US(CPU), .CHR_US(CHR), .LCR_US(LCR), .LDL_US(LDL),
                 .LDS_US(LDS), .BLINK_US(BLK)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bus_wr = 0; bus_addr = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    for (int i = 0; i < 32; i++) model[i] = 8'h20;
    cur = 0; len = 32;
  endtask

  task automatic raw_wr(input logic a, input logic [7:0] b);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = b;
    @(negedge clk); bus_wr = 0; bus_addr = 0; #1;
  endtask

  task automatic send(input logic [7:0] b, output int n);
    raw_wr(1'b0, b);
    n = 0;
    while (bus_rdata[3] == 1'b0 && n < 1000) begin
      n++; @(negedge clk); #1;
    end
  endtask

  task automatic put_char(input logic [7:0] c, input bit chk_busy);
    int n;
    send(c, n);
    if (chk_busy) check("R2 char busy", n, CHR*CPU);
    model[cur] = {2'b00, c[5:0]};
    cur = (cur + 1 >= len) ? 0 : cur + 1;
  endtask

  task automatic peek(input int p, output logic [7:0] ch, output logic on);
    @(negedge clk); view_pos = p[4:0]; #1; ch = view_char; on = view_on;
  endtask

  task automatic measure(input bit use_cur, output int n);
    int g = 0;
    logic v0;
    @(negedge clk); #1;
    v0 = use_cur ? view_cursor : view_on;
    while ((use_cur ? view_cursor : view_on) == v0 && g < 1000) begin
      g++; @(negedge clk); #1;
    end
    n = 0;
    while ((use_cur ? view_cursor : view_on) != v0 && n < 1000) begin
      n++; @(negedge clk); #1;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] ch;
    logic on;
    do_reset();
    #1;
    check("R1 status", bus_rdata, 8'h08);
    bus_addr = 1; #1;
    check("R10 outreg reset", bus_rdata, 0);
    bus_addr = 0;
    for (int p = 0; p < 32; p++) begin
      peek(p, ch, on);
      check("R1 cell", ch, 8'h20);
      check("R1 dark", on, 0);
    end

    send(8'h44, n);
    check("R2 lds busy", n, LDS*CPU);
    check("R7 status e", bus_rdata, 8'h0C);

    for (int i = 0; i < 32; i++) put_char(8'((i*7+1) & 8'h3F), i < 4);
    for (int p = 0; p < 32; p++) begin
      peek(p, ch, on);
      check("R3 cell", ch, model[p]);
      check("R6 lit full length", on, 1);
    end
    put_char(8'h3F, 1);
    peek(0, ch, on);
    check("R4 wrap to 0", ch, 8'h3F);

    for (int p = 0; p < 32; p++) begin
      send(8'h80 | 8'(p), n);
      if (p == 3) check("R2 lcr busy", n, LCR*CPU);
      bus_addr = 1; #1;
      check("R5 outreg", bus_rdata, model[p]);
      bus_addr = 0;
    end
    cur = 31;

    send(8'hA4, n);
    check("R2 ldl busy", n, LDL*CPU);
    len = 5; cur = 0;
    for (int i = 0; i < 6; i++) put_char(8'h10 + 8'(i), 0);
    for (int p = 0; p < 32; p++) begin
      peek(p, ch, on);
      check("R4 cell after short wrap", ch, model[p]);
      check("R6 lit only below length", on, p < 5);
    end

    send(8'hC7, n);
    check("R2 nop busy", n, CHR*CPU);
    check("R11 status kept", bus_rdata, 8'h0C);
    put_char(8'h2A, 0);
    peek(1, ch, on);
    check("R11 cursor kept", ch, 8'h2A);
    peek(2, ch, on);
    check("R11 no store", ch, model[2]);

    raw_wr(1'b1, 8'h05);
    check("R10 addr1 write no busy", bus_rdata, 8'h0C);
    put_char(8'h33, 0);
    peek(2, ch, on);
    check("R10 addr1 write no store", ch, 8'h33);
    peek(3, ch, on);
    check("R10 addr1 write no store next", ch, model[3]);

    send(8'h46, n);
    check("R7 status ed", bus_rdata, 8'h0E);
    view_pos = 0;
    measure(0, n);
    check("R9 display blink", n, BLK*CPU);
    send(8'h45, n);
    view_pos = 5'(cur);
    measure(1, n);
    check("R9 cursor blink", n, BLK*CPU);
    check("R9 lit without d", view_on, 1);
    view_pos = 5'(cur + 1); #1;
    check("R9 no cursor elsewhere", view_cursor, 0);

    raw_wr(1'b0, 8'h01);
    model[cur] = 8'h01;
    cur = (cur + 1 >= len) ? 0 : cur + 1;
    raw_wr(1'b0, 8'h22);
    check("R8 err and busy", bus_rdata & 8'h18, 8'h10);
    n = 0;
    while (bus_rdata[3] == 1'b0 && n < 1000) begin n++; @(negedge clk); #1; end
    peek(cur, ch, on);
    check("R8 no store", ch, model[cur]);
    put_char(8'h15, 0);
    peek((cur + len - 1) % len, ch, on);
    check("R8 cursor kept", ch, 8'h15);
    check("R8 err sticky", bus_rdata[4], 1);

    do_reset();
    #1;
    check("R1 status after reset", bus_rdata, 8'h08);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule